// File: doc/BRIEF.md
# Brownout Reset Sequencer with Idle Timer

This block turns two digitized supply-monitor flags into one chip-wide, active-high reset. The first flag says the supply is above a low trigger level. The second says it is above the brownout threshold. While the supply sits under the trigger level, reset is forced on. Once the supply crosses that level, a fixed power-up delay runs. A down-counting idle timer is then loaded with a value near the top of its low byte. Reset drops only when that timer underflows, and the timer advances on a one-cycle tick strobe. A dip under the brownout threshold re-arms the countdown. A dip under the trigger level re-arms the whole sequence, delay included.

A strap input disables the brownout function. In that mode the block never raises reset on its own, and the active-low external reset pin is the only source. The external pin is always merged into the output, so a reset from the supply logic and a reset from the pin act the same way. The low nibble of the timer preset comes from an input, which makes any start value from 0xF0 to 0xFF selectable.

Top module: `bor_reset_seq`

## Requirements
- R1: While `supply_trig_i` is low, `rst_o` is high at once (asynchronously) and `idle_cnt_o` reads {PRESET_HI, 4'h0}, which is 0x00F0 by default.
- R2: The trigger flag is used only after it passes through SYNC_STAGES flops. After it is seen high, the sequencer spends exactly DELAY_CYCLES clock cycles in the power-up delay. During that delay the timer is reloaded every cycle with {PRESET_HI, preset_lo_i} and does not count, even when the brownout flag is high.
- R3: The countdown runs only after the delay has ended and the synchronized brownout flag is high. The timer drops by one on each cycle where `tick_en_i` is high, and holds its value otherwise.
- R4: `rst_o` falls in the cycle after a tick arrives with the timer at zero. A preset of P therefore needs P+1 ticks.
- R5: After release, the internal reset stays low and `idle_cnt_o` holds at zero for as long as the synchronized brownout flag stays high.
- R6: A low synchronized brownout flag during the countdown or after release raises the internal reset on the next edge and reloads the preset. When the flag returns, the countdown restarts without a new power-up delay.
- R7: Any low level on `supply_trig_i` restarts the full sequence, including the power-up delay.
- R8: With `bor_en_i` low the block raises no internal reset, and `idle_cnt_o` is zero from the next edge on.
- R9: `rst_o` is the OR of the internal reset and the inverted `ext_rst_n_i`. The pin acts combinationally in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| supply_trig_i | input | 1 | High when the supply is above the trigger level; low clears the sequencer asynchronously |
| supply_bor_i | input | 1 | High when the supply is above the brownout threshold |
| bor_en_i | input | 1 | Brownout function enable strap |
| ext_rst_n_i | input | 1 | External reset pin, active low |
| preset_lo_i | input | 4 | Low nibble of the idle-timer preset |
| tick_en_i | input | 1 | One-cycle strobe per idle-timer period |
| rst_o | output | 1 | Chip reset, active high |
| idle_cnt_o | output | CNT_W | Current idle-timer value |

## Verification
The bench targets the exact length of the delay, the off-by-one at underflow, and timer ticks that stop partway through the countdown. A design that counts during the delay, or releases on reaching zero rather than on the tick that follows, leaves reset on for the wrong number of cycles. The bench drops the brownout flag both after release and during the countdown. A design that reruns the power-up delay there, or fails to reload the preset, drifts from the model. Trigger dips must restart the delay. With the strap off, no internal reset may appear, and the external pin must pass straight through in every state.

// File: rtl/bor_seq_pkg.sv
package bor_seq_pkg;
   typedef enum logic [2:0] {
      ST_LOW   = 3'd0,
      ST_DELAY = 3'd1,
      ST_WAIT  = 3'd2,
      ST_COUNT = 3'd3,
      ST_RUN   = 3'd4
   } seq_state_e;
endpackage

// File: rtl/bor_flag_sync.sv
module bor_flag_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic clr_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bor_flag_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d_i};
   end

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/bor_delay_ctr.sv
module bor_delay_ctr #(
   parameter int unsigned CYCLES = 12
) (
   input  logic clk,
   input  logic clr_n,
   input  logic run_i,
   output logic done_o
);
   localparam int unsigned W = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [W-1:0] LAST = W'(CYCLES - 1);

   generate
      if (CYCLES < 1) begin : g_bad_cycles
         $error("bor_delay_ctr: CYCLES must be at least 1");
      end
   endgenerate

   logic [W-1:0] elapsed;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)               elapsed <= '0;
      else if (!run_i)          elapsed <= '0;
      else if (elapsed != LAST) elapsed <= elapsed + 1'b1;
   end

   assign done_o = run_i && (elapsed == LAST);

   // R2: the counter never passes its last value while the delay runs
   p_delay_cap_r2: assert property (@(posedge clk) disable iff (!clr_n)
      (run_i && elapsed == LAST) |=> (elapsed == LAST || elapsed == '0));
endmodule

// File: rtl/bor_idle_timer.sv
module bor_idle_timer #(
   parameter int unsigned CNT_W     = 16,
   parameter int unsigned PRESET_HI = 'h00F
) (
   input  logic             clk,
   input  logic             clr_n,
   input  logic             wipe_i,
   input  logic             load_i,
   input  logic             dec_i,
   input  logic [3:0]       preset_lo_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             zero_o
);
   localparam logic [CNT_W-1:0] HI_PART = CNT_W'(PRESET_HI) << 4;

   generate
      if (CNT_W < 8) begin : g_bad_width
         $error("bor_idle_timer: CNT_W must be at least 8");
      end
      if (PRESET_HI >= (1 << (CNT_W - 4))) begin : g_bad_hi
         $error("bor_idle_timer: PRESET_HI does not fit above the low nibble");
      end
   endgenerate

   logic [CNT_W-1:0] value;

   always_ff @(posedge clk or negedge clr_n) begin
      if (!clr_n)      value <= HI_PART;
      else if (wipe_i) value <= '0;
      else if (load_i) value <= HI_PART | CNT_W'(preset_lo_i);
      else if (dec_i)  value <= value - 1'b1;
   end

   assign cnt_o  = value;
   assign zero_o = (value == '0);

   // R4: the sequencer never asks to decrement past zero
   p_dec_legal_r4: assert property (@(posedge clk) disable iff (!clr_n)
      dec_i |-> !zero_o);
endmodule

// File: rtl/bor_reset_seq.sv
module bor_reset_seq
   import bor_seq_pkg::*;
#(
   parameter int unsigned DELAY_CYCLES = 12,
   parameter int unsigned CNT_W        = 16,
   parameter int unsigned PRESET_HI    = 'h00F,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             supply_trig_i,
   input  logic             supply_bor_i,
   input  logic             bor_en_i,
   input  logic             ext_rst_n_i,
   input  logic [3:0]       preset_lo_i,
   input  logic             tick_en_i,
   output logic             rst_o,
   output logic [CNT_W-1:0] idle_cnt_o
);
   localparam logic [CNT_W-1:0] HI_CMP = CNT_W'(PRESET_HI);

   logic       trig_q, bor_q;
   logic       dly_done, tmr_zero;
   logic       tmr_load, tmr_dec, tmr_wipe, underflow;
   logic       int_rst;
   seq_state_e st, st_nx;

   bor_flag_sync #(.STAGES(SYNC_STAGES)) i_trig_sync (
      .clk(clk), .clr_n(supply_trig_i), .d_i(1'b1), .q_o(trig_q));

   bor_flag_sync #(.STAGES(SYNC_STAGES)) i_bor_sync (
      .clk(clk), .clr_n(supply_trig_i), .d_i(supply_bor_i), .q_o(bor_q));

   bor_delay_ctr #(.CYCLES(DELAY_CYCLES)) i_delay (
      .clk(clk), .clr_n(supply_trig_i),
      .run_i(bor_en_i && st == ST_DELAY), .done_o(dly_done));

   bor_idle_timer #(.CNT_W(CNT_W), .PRESET_HI(PRESET_HI)) i_timer (
      .clk(clk), .clr_n(supply_trig_i), .wipe_i(tmr_wipe),
      .load_i(tmr_load), .dec_i(tmr_dec), .preset_lo_i(preset_lo_i),
      .cnt_o(idle_cnt_o), .zero_o(tmr_zero));

   assign underflow = (st == ST_COUNT) && bor_q && tick_en_i && tmr_zero;
   assign tmr_wipe  = !bor_en_i;
   assign tmr_dec   = bor_en_i && (st == ST_COUNT) && bor_q && tick_en_i && !tmr_zero;
   assign tmr_load  = bor_en_i &&
                      ((st == ST_LOW) || (st == ST_DELAY) || (st == ST_WAIT) ||
                       (((st == ST_COUNT) || (st == ST_RUN)) && !bor_q));

   always_comb begin
      st_nx = st;
      if (!bor_en_i) begin
         st_nx = ST_LOW;
      end else begin
         unique case (st)
            ST_LOW:   if (trig_q)    st_nx = ST_DELAY;
            ST_DELAY: if (dly_done)  st_nx = ST_WAIT;
            ST_WAIT:  if (bor_q)     st_nx = ST_COUNT;
            ST_COUNT: if (!bor_q)    st_nx = ST_WAIT;
                      else if (underflow) st_nx = ST_RUN;
            ST_RUN:   if (!bor_q)    st_nx = ST_WAIT;
            default:                 st_nx = ST_LOW;
         endcase
      end
   end

   always_ff @(posedge clk or negedge supply_trig_i) begin
      if (!supply_trig_i) st <= ST_LOW;
      else                st <= st_nx;
   end

   assign int_rst = bor_en_i && (st != ST_RUN);
   assign rst_o   = int_rst || !ext_rst_n_i;

   // R4: internal reset falls only after a tick seen with the timer at zero
   p_release_on_underflow_r4: assert property (@(posedge clk) disable iff (!supply_trig_i)
      (bor_en_i && $past(bor_en_i) && $fell(int_rst)) |-> $past(tick_en_i && tmr_zero));

   // R6: a low brownout flag always leads out of the released state
   p_bor_drop_r6: assert property (@(posedge clk) disable iff (!supply_trig_i)
      (bor_en_i && !bor_q) |=> (st != ST_RUN));

   // R2: during the delay the timer carries the preset's high part
   p_preset_in_delay_r2: assert property (@(posedge clk) disable iff (!supply_trig_i)
      (bor_en_i && st == ST_DELAY) |=> ((idle_cnt_o >> 4) == HI_CMP));

   // R3: no tick, no movement of the timer while counting
   p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (!supply_trig_i)
      (bor_en_i && st == ST_COUNT && bor_q && !tick_en_i) |=> $stable(idle_cnt_o));

   // R8: with the strap off the timer reads zero after the next edge
   p_disabled_zero_r8: assert property (@(posedge clk) disable iff (!supply_trig_i)
      !bor_en_i |=> (idle_cnt_o == '0));

   // R5: once released with the flag steady, the timer stays at zero
   p_run_quiet_r5: assert property (@(posedge clk) disable iff (!supply_trig_i)
      (bor_en_i && st == ST_RUN && bor_q) |=> (idle_cnt_o == '0));
endmodule

// File: tb/test_bor_reset_seq.sv
`timescale 1ns/1ps
module test_bor_reset_seq;
   localparam int DLY = 12;
   localparam int CW  = 16;

   logic          clk = 1'b0;
   logic          trig = 1'b0, bor = 1'b0, en = 1'b1, ext_n = 1'b1, tick = 1'b0;
   logic [3:0]    plo = 4'h5;
   logic          rst_o;
   logic [CW-1:0] cnt_o;

   int    n_vec = 0, n_bad = 0;
   string cur_req = "R1";
   bit    tick_auto = 1'b0;
   int    tick_div = 1, tick_ph = 0;

   // behavioural model state
   int m_phase = 0;   // 0 low, 1 delay, 2 wait, 3 count, 4 released
   int m_cnt   = 'hF0;
   int m_dly   = 0;
   bit m_t1 = 0, m_t2 = 0, m_b1 = 0, m_b2 = 0;

   always #2 clk = ~clk;

   bor_reset_seq #(.DELAY_CYCLES(DLY), .CNT_W(CW)) i_bor_reset_seq (
      .clk(clk), .supply_trig_i(trig), .supply_bor_i(bor), .bor_en_i(en),
      .ext_rst_n_i(ext_n), .preset_lo_i(plo), .tick_en_i(tick),
      .rst_o(rst_o), .idle_cnt_o(cnt_o));

   always @(posedge clk) begin
      int pre;
      pre = 'hF0 + int'(plo);
      if (!trig) begin
         m_phase = 0; m_cnt = 'hF0; m_dly = 0;
         m_t1 = 0; m_t2 = 0; m_b1 = 0; m_b2 = 0;
      end else begin
         if (!en) begin
            m_phase = 0; m_cnt = 0;
         end else begin
            case (m_phase)
               0: begin m_cnt = pre; if (m_t2) begin m_phase = 1; m_dly = 0; end end
               1: begin
                     m_cnt = pre;
                     if (m_dly == DLY - 1) m_phase = 2; else m_dly++;
                  end
               2: begin m_cnt = pre; if (m_b2) m_phase = 3; end
               3: begin
                     if (!m_b2) begin m_phase = 2; m_cnt = pre; end
                     else if (tick) begin
                        if (m_cnt == 0) m_phase = 4; else m_cnt--;
                     end
                  end
               default: if (!m_b2) begin m_phase = 2; m_cnt = pre; end
            endcase
            if (m_phase != 1) m_dly = 0;
         end
         m_t2 = m_t1; m_t1 = 1'b1;
         m_b2 = m_b1; m_b1 = bor;
      end
   end

   task automatic check_now();
      bit exp_rst;
      int exp_cnt;
      exp_cnt = trig ? m_cnt : 'hF0;
      exp_rst = (!trig && en) || (en && m_phase != 4) || !ext_n;
      n_vec++;
      if (rst_o !== exp_rst || cnt_o !== CW'(exp_cnt)) begin
         n_bad++;
         $display("FAIL %s t=%0t rst_o=%b exp %b idle_cnt=%h exp %h",
                  cur_req, $time, rst_o, exp_rst, cnt_o, CW'(exp_cnt));
      end
   endtask

   task automatic run(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         check_now();
         if (tick_auto) begin
            tick_ph = (tick_ph + 1) % tick_div;
            tick = (tick_ph == 0);
         end else tick = 1'b0;
      end
   endtask

   initial begin
      #(4 * 100000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      // R1: supply below trigger holds reset
      cur_req = "R1";
      run(6);
      // R2 / R3 / R4: power-up, delay, countdown with a tick every third cycle
      cur_req = "R2";
      trig = 1'b1; bor = 1'b1;
      run(DLY + 6);
      cur_req = "R3";
      tick_auto = 1'b1; tick_div = 3;
      run(300);
      tick_auto = 1'b0;           // R3: ticks pause mid-count, timer must hold
      run(25);
      cur_req = "R4";
      tick_auto = 1'b1;
      run(500);
      // R5: released, stays released
      cur_req = "R5";
      run(60);
      // R9: external pin merges in while released
      cur_req = "R9";
      ext_n = 1'b0; run(4); ext_n = 1'b1; run(3);
      // R6: brownout dip after release, restart without delay, preset 0x0
      cur_req = "R6";
      bor = 1'b0; plo = 4'h0; run(6);
      bor = 1'b1; tick_div = 1; run(120);
      bor = 1'b0; run(3);         // R6: dip during the countdown
      bor = 1'b1; run(300);
      // R7: trigger dip restarts the delay, preset 0xF
      cur_req = "R7";
      plo = 4'hF; trig = 1'b0; run(2);
      trig = 1'b1; run(320);
      // R8: strap off, no internal reset, external pin alone
      cur_req = "R8";
      en = 1'b0; bor = 1'b0; run(10);
      trig = 1'b0; run(3); trig = 1'b1; run(10);
      cur_req = "R9";
      ext_n = 1'b0; run(3); ext_n = 1'b1; run(2);
      // R2: strap back on starts a full sequence, pin pulsed during countdown
      cur_req = "R2";
      en = 1'b1; bor = 1'b1; plo = 4'h3; tick_div = 2; run(DLY + 40);
      cur_req = "R9";
      ext_n = 1'b0; run(2); ext_n = 1'b1;
      cur_req = "R4";
      run(600);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule